// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the frequency of one clock picked from up to 128 candidate clocks. Software programs a control word that holds a gate length, a source index, an enable bit and a run bit. When enable and run are both set while the meter is idle, the meter opens a gate window. The window lasts a whole number of microsecond ticks, and the ticks come from a prescaler driven by the system clock. While the window is open, a counter clocked by the selected source counts that clock's rising edges. When the window closes, the count is moved back into the system domain and latched into a 16-bit result register. A busy flag in the control word tells software when the result is final.

The gate field holds the window length minus one, so a field value of D-1 gives a window of D microseconds. The frequency in Hz is the count times 1,000,000 divided by D. The count stops at 0xFFFF rather than wrapping, so a reading of 0xFFFF means the true count overflowed.

The control process is a four-state machine:
- **IDLE**: waits for a run request.
- **GATE**: the window is open and the microsecond ticks are counted.
- **DRAIN**: the window is closed and the meter waits for the source-side counter to confirm that it has stopped.
- **LATCH**: copies the count into the result register.

The transitions are:
- IDLE→GATE on a control write with enable and run both set.
- GATE→DRAIN on the tick that completes D ticks.
- DRAIN→LATCH once the source-side activity indication reads low.
- LATCH→IDLE unconditionally.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control word (byte offset 0x4) and the result word (byte offset 0xC) both read 0, and busy (control bit 31) is 0.
- R2: Control field positions: bits 15:0 gate length minus one, bit 16 enable, bit 17 continuous, bit 18 interrupt enable, bit 19 run, bits 26:20 source index. Every one of these bits reads back as written, and bits 30:27 read 0.
- R3: A control write with bit 16 and bit 19 both set while idle makes busy read 1 from the next cycle on. A write with only one of the two bits set does not set busy.
- R4: The gate window lasts (field+1) ticks of SYS_CLK_HZ/1,000,000 system cycles each. Busy stays high for at least that many cycles.
- R5: The result equals the number of rising edges of the selected source inside the window, within ±3 edges.
- R6: Any 7-bit source index is accepted. A source that does not toggle yields a result of 0.
- R7: The count saturates at 0xFFFF and does not wrap.
- R8: Only the low 16 bits of the result word carry the count. Bits 31:16 read 0.
- R9: After a run, rewriting the control word with enable cleared, or writing it to 0, leaves the result unchanged.
- R10: Byte offsets 0x0 and 0x8 read 0. Writes to them change neither the control word nor the result.
- R11: Bits 17 and 18 are stored but have no effect on a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also drives the microsecond prescaler |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_addr | input | 4 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr; combinational |
| src_clk | input | NUM_SRC | Candidate clocks to be measured |

## Verification
Busy is due on the first clock edge after the starting write. The bench therefore samples it at the falling edge that follows that write. The gate closes exactly D×TICK_DIV cycles after the write. DRAIN then adds a few cycles for the two-flop return path, and LATCH adds one more, so the bench counts the busy cycles and checks them against a band whose lower bound is exact. The result is read only after busy has been seen low. A scoreboard pairs each read with the count that the driver queued from the source frequency times the gate length. A tolerance of three edges covers synchronizer phase, except in the saturation and quiet-source cases, which must match exactly.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
    localparam int REG_AW  = 4;
    localparam int DATA_W  = 32;
    localparam int DUR_W   = 16;
    localparam int SRC_W   = 7;
    localparam int CNT_W   = 16;

    localparam logic [REG_AW-1:0] OFS_DUTY   = 4'h0;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 4'h4;
    localparam logic [REG_AW-1:0] OFS_SPARE  = 4'h8;
    localparam logic [REG_AW-1:0] OFS_RESULT = 4'hC;

    localparam int BIT_EN   = 16;
    localparam int BIT_RUN  = 19;
    localparam int BIT_BUSY = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATE,
        ST_DRAIN,
        ST_LATCH
    } fm_state_e;

    // Layout matches bits 26:0 of the control word.
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             run;
        logic             irq_en;
        logic             cont;
        logic             en;
        logic [DUR_W-1:0] dur;
    } fm_ctrl_t;

    localparam int CTRL_W = $bits(fm_ctrl_t);
    localparam int PAD_W  = DATA_W - 1 - CTRL_W;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/fm_tick_gen.sv
`timescale 1ns/1ps
module fm_tick_gen #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (clr)           pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
    end

    assign tick = !clr && (pre_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R4
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter #(
    parameter int CW = 16
) (
    input  logic          meas_clk,
    input  logic          rst_n,
    input  logic          gate_sys,
    output logic [CW-1:0] count,
    output logic          active
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic gate_s;
    logic gate_d;

    fm_sync #(.STAGES(2)) u_gate_sync (
        .clk   (meas_clk),
        .rst_n (rst_n),
        .d     (gate_sys),
        .q     (gate_s)
    );

    always_ff @(posedge meas_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_d <= 1'b0;
            count  <= '0;
        end else begin
            gate_d <= gate_s;
            if (gate_s && !gate_d)
                count <= '0;
            else if (gate_s && count != CNT_MAX)
                count <= count + 1'b1;
        end
    end

    assign active = gate_d;

    // R7
    cnt_sat_chk: assert property (@(posedge meas_clk) disable iff (!rst_n)
        (count == CNT_MAX && gate_s && gate_d) |=> count == CNT_MAX);
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
    import fm_pkg::*;
#(
    parameter int SYS_CLK_HZ = 200_000_000,
    parameter int NUM_SRC    = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  src_clk
);
    localparam int TICK_DIV = SYS_CLK_HZ / 1_000_000;
    localparam int SRC_SPAN = 1 << SRC_W;

    fm_state_e            state_q, state_d;
    fm_ctrl_t             ctrl_q;
    logic [SRC_W-1:0]     src_q;
    logic [DUR_W-1:0]     dur_q;
    logic [DUR_W-1:0]     tick_cnt_q;
    logic                 seen_q;
    logic [CNT_W-1:0]     result_q;
    logic [SRC_SPAN-1:0]  src_pad;
    logic                 meas_clk;
    logic                 tick;
    logic                 gate;
    logic                 busy;
    logic                 tick_clr;
    logic                 ack_meas;
    logic                 ack_sys;
    logic [CNT_W-1:0]     meas_count;
    logic                 ctrl_wr;
    logic                 start;
    logic                 unused_wdata;

    assign ctrl_wr      = bus_wr && (bus_addr == OFS_CTRL);
    assign start        = ctrl_wr && bus_wdata[BIT_EN] && bus_wdata[BIT_RUN];
    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    // Source multiplexer; indices above NUM_SRC read a quiet clock.
    generate
        if (NUM_SRC < SRC_SPAN) begin : g_pad
            assign src_pad = {{(SRC_SPAN-NUM_SRC){1'b0}}, src_clk};
        end else begin : g_full
            assign src_pad = src_clk[SRC_SPAN-1:0];
        end
    endgenerate
    assign meas_clk = src_pad[src_q];

    fm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    fm_edge_counter #(.CW(CNT_W)) u_cnt (
        .meas_clk (meas_clk),
        .rst_n    (rst_n),
        .gate_sys (gate),
        .count    (meas_count),
        .active   (ack_meas)
    );

    fm_sync #(.STAGES(2)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_meas),
        .q     (ack_sys)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_GATE;
            ST_GATE:  if (tick && tick_cnt_q == dur_q) state_d = ST_DRAIN;
            ST_DRAIN: if (!ack_sys) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        gate     = 1'b0;
        busy     = 1'b1;
        tick_clr = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_GATE:  begin gate = 1'b1; tick_clr = 1'b0; end
            ST_DRAIN: ;
            ST_LATCH: ;
            default:  busy = 1'b0;
        endcase
    end

    // Registers and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            src_q      <= '0;
            dur_q      <= '0;
            tick_cnt_q <= '0;
            seen_q     <= 1'b0;
            result_q   <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= fm_ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (state_q == ST_IDLE && start) begin
                src_q      <= bus_wdata[BIT_RUN+1 +: SRC_W];
                dur_q      <= bus_wdata[DUR_W-1:0];
                tick_cnt_q <= '0;
                seen_q     <= 1'b0;
            end
            if (state_q == ST_GATE && tick)
                tick_cnt_q <= tick_cnt_q + 1'b1;
            if ((state_q == ST_GATE || state_q == ST_DRAIN) && ack_sys)
                seen_q <= 1'b1;
            if (state_q == ST_LATCH)
                result_q <= seen_q ? meas_count : '0;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:   bus_rdata = {busy, {PAD_W{1'b0}}, ctrl_q};
            OFS_RESULT: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, result_q};
            default:    bus_rdata = '0;
        endcase
    end

    // Gate-length checker
    logic [31:0] gate_cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gate_cyc_q <= '0;
        else if (gate) gate_cyc_q <= gate_cyc_q + 1'b1;
        else           gate_cyc_q <= '0;
    end

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |=> bus_rdata[BIT_BUSY] || bus_addr != OFS_CTRL);

    // R4
    gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> gate_cyc_q == 32'((int'(dur_q) + 1) * TICK_DIV));

    // R6
    quiet_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && !seen_q) |=> result_q == '0);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(result_q));
endmodule

// File: tb/freq_meter_tb.sv
`timescale 1ns/1ps
module freq_meter_tb;
    import fm_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = OFS_CTRL;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] src_clk;
    logic c25 = 1'b0, c100 = 1'b0, c10 = 1'b0, c400 = 1'b0;

    always #2.5  clk  = ~clk;
    always #20   c25  = ~c25;
    always #5    c100 = ~c100;
    always #50   c10  = ~c10;
    always #1.25 c400 = ~c400;

    // src 3 = 25 MHz, 17 = 100 MHz, 64 = 10 MHz, 127 = 400 MHz, rest quiet
    assign src_clk = {c400, 62'b0, c10, 46'b0, c100, 13'b0, c25, 3'b0};

    freq_meter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_clk   (src_clk)
    );

    localparam int TDIV = 200;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // scoreboard queues
    int    exp_q[$];
    int    tol_q[$];
    string req_q[$];
    bit    mon_req = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = OFS_CTRL;
    endtask

    task automatic reg_rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = OFS_CTRL;
    endtask

    // driver: queue the expected count, start a run, wait for busy to drop
    task automatic measure(string req, int src, int dur, logic [31:0] flags,
                           int exp, int tol);
        logic [31:0] ctl;
        int cyc;
        ctl = (32'(src) << 20) | (32'd1 << 19) | (32'd1 << 16) | flags | 32'(dur - 1);
        exp_q.push_back(exp); tol_q.push_back(tol); req_q.push_back(req);
        reg_wr(OFS_CTRL, ctl);
        // R3: busy set one cycle after the start write
        check("R3 busy after start", {31'b0, bus_rdata[31]}, 32'd1);
        cyc = 0;
        while (bus_rdata[31] && cyc < 100000) begin
            @(negedge clk);
            cyc++;
        end
        // R4: busy spans at least the gate window
        n_chk++;
        if (cyc < dur * TDIV || cyc > dur * TDIV + 80) begin
            n_fail++;
            $display("FAIL R4 busy cycles actual=%0d expected=%0d..%0d",
                     cyc, dur * TDIV, dur * TDIV + 80);
        end
        bus_addr = OFS_RESULT;
        #1;
        mon_req = 1'b1;
        wait (!mon_req);
        bus_addr = OFS_CTRL;
    endtask

    // monitor: pop the expected item and compare with the result word
    initial begin
        forever begin
            int e, t, d;
            string r;
            logic [31:0] act;
            wait (mon_req);
            act = bus_rdata;
            e = exp_q.pop_front(); t = tol_q.pop_front(); r = req_q.pop_front();
            d = int'(act[15:0]) - e;
            if (d < 0) d = -d;
            n_chk++;
            if (d > t) begin
                n_fail++;
                $display("FAIL %s count actual=%0d expected=%0d+/-%0d", r, act[15:0], e, t);
            end
            // R8: upper result bits zero
            check("R8 result upper bits", {16'b0, act[31:16]}, 32'd0);
            mon_req = 1'b0;
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(OFS_CTRL, v);   check("R1 ctrl after reset", v, 32'd0);
        reg_rd(OFS_RESULT, v); check("R1 result after reset", v, 32'd0);

        // R2 field readback; R3 run without enable does not start
        reg_wr(OFS_CTRL, 32'h02AE_1234);
        check("R3 run only no busy", {31'b0, bus_rdata[31]}, 32'd0);
        reg_rd(OFS_CTRL, v); check("R2 readback", v, 32'h02AE_1234);
        reg_wr(OFS_CTRL, 32'h0001_0005);
        reg_rd(OFS_CTRL, v); check("R3 enable only no busy", v, 32'h0001_0005);

        measure("R5 25MHz", 3, 4, 32'd0, 100, 3);
        measure("R5 100MHz", 17, 10, 32'd0, 1000, 3);
        measure("R6 10MHz idx64", 64, 3, 32'd0, 30, 3);
        measure("R6 quiet idx100", 100, 2, 32'd0, 0, 0);
        measure("R11 cont+irq set", 17, 10, 32'h0006_0000, 1000, 3);
        reg_rd(OFS_CTRL, v);
        check("R11 bits stored", v, 32'h011F_0009);
        measure("R7 saturation", 127, 170, 32'd0, 32'hFFFF, 0);

        // R9 clear enable, then zero the control word
        reg_wr(OFS_CTRL, 32'h07F8_00A9);
        reg_rd(OFS_RESULT, v); check("R9 result after enable clear", v, 32'h0000_FFFF);
        reg_wr(OFS_CTRL, 32'd0);
        reg_rd(OFS_CTRL, v);   check("R9 ctrl zero", v, 32'd0);
        reg_rd(OFS_RESULT, v); check("R9 result after zero", v, 32'h0000_FFFF);

        // R10 inert offsets
        reg_wr(OFS_DUTY, 32'hFFFF_FFFF);
        reg_wr(OFS_SPARE, 32'hFFFF_FFFF);
        reg_rd(OFS_DUTY, v);   check("R10 offset 0x0", v, 32'd0);
        reg_rd(OFS_SPARE, v);  check("R10 offset 0x8", v, 32'd0);
        reg_rd(OFS_CTRL, v);   check("R10 ctrl untouched", v, 32'd0);
        reg_rd(OFS_RESULT, v); check("R10 result untouched", v, 32'h0000_FFFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule